// File: doc/BRIEF.md
# Circular audio delay-line addresser

This block sequences the accesses of a memory that serves as an audio delay line. When a sample strobe arrives it issues a read at the current buffer pointer, which returns the sample stored there on the previous pass. It then issues a write of the new sample to that same location and steps the pointer. The pointer runs from zero to a programmable terminal count and then returns to zero. The delay in sample periods is therefore the terminal count plus one.

The block drives the pointer onto the memory's two address fields. Only the order of visits matters, not which locations sit next to each other, so the fast-changing low pointer bits go to the column field and the slow high bits go to the row field. Refresh then comes from normal cycling, provided the loop stays below a ceiling set at build time. A new terminal count is taken only when the pointer wraps, so the pointer never runs outside the loop it is traversing.

The memory is expected to return read data one clock after a read request. Converters and memory signal timing are handled elsewhere.

Top module: `delay_line_addr`

## Requirements
- R1: During and after a synchronous active-low reset, `mem_rd`, `mem_wr` and `dly_out` are 0, and the pointer is 0 (`mem_row` = 0, `mem_col` = 0).
- R2: A `smp_stb` sampled high while idle raises `mem_rd` for exactly the next cycle, addressed at the current pointer. `mem_wr` is low in that cycle.
- R3: In the cycle after the read, `mem_wr` is high for exactly one cycle. The address is unchanged and `mem_wdata` equals the `smp_in` value sampled with the strobe. The read always precedes the write, and the two are never high together.
- R4: `dly_out` is loaded from `mem_rdata` at the clock edge that ends the write cycle. At every other edge it holds its value.
- R5: After each access the pointer steps by one, or returns to 0 when it equals the active terminal count. The delayed sample therefore equals the input given L strobes earlier, where L is the terminal count plus one (0 before the buffer has filled).
- R6: The pointer's low COL_W bits appear on `mem_col` and its upper ROW_W bits on `mem_row`.
- R7: The terminal count is taken from `loop_last` only at reset and at a pointer wrap. A change at any other time leaves the current pass unaffected.
- R8: A `loop_last` value above the parameter MAX_LAST is replaced by MAX_LAST, which bounds the loop to the refresh interval.
- R9: A strobe that arrives while an access is in progress is ignored and starts no extra read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Sample-period strobe |
| smp_in | input | SMP_W | New sample to store |
| loop_last | input | ROW_W+COL_W | Requested terminal count (delay minus one) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_row | output | ROW_W | Row address field (slow pointer bits) |
| mem_col | output | COL_W | Column address field (fast pointer bits) |
| mem_wdata | output | SMP_W | Sample to write |
| mem_rdata | input | SMP_W | Read data, valid one cycle after `mem_rd` |
| dly_out | output | SMP_W | Delayed sample |

## Verification
With a strobe sampled at edge E0, the read request and its address are due after E0. The write request and its data are due after E1, and the new delayed sample after E2. A further idle cycle follows to confirm that the output holds and that no extra read starts. The bench drives inputs at falling edges and samples each result at the falling edge that follows the edge at which the result is due. It predicts the address and the delayed value from its own pointer and buffer arithmetic, and sweeps several loop lengths, including a capped value and a one-sample loop.

// File: rtl/delay_line_addr.sv
module delay_line_addr #(
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned COL_W    = 8,
  parameter int unsigned ROW_W    = 7,
  parameter int unsigned MAX_LAST = (1 << (ROW_W + COL_W)) - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic [SMP_W-1:0]         smp_in,
  input  logic [ROW_W+COL_W-1:0]   loop_last,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [ROW_W-1:0]         mem_row,
  output logic [COL_W-1:0]         mem_col,
  output logic [SMP_W-1:0]         mem_wdata,
  input  logic [SMP_W-1:0]         mem_rdata,
  output logic [SMP_W-1:0]         dly_out
);

  localparam int unsigned PTR_W = ROW_W + COL_W;
  localparam logic [PTR_W-1:0] LAST_CAP = PTR_W'(MAX_LAST);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_t;

  st_t              st_q;
  logic [PTR_W-1:0] ptr_q, last_q;
  logic [SMP_W-1:0] smp_q, dly_q;
  logic             seen_q;

  wire [PTR_W-1:0] last_lim = (loop_last > LAST_CAP) ? LAST_CAP : loop_last;
  wire             at_end   = (ptr_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      last_q <= last_lim;
      smp_q  <= '0;
      dly_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (smp_stb) begin
          st_q  <= ST_RD;
          smp_q <= smp_in;
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          st_q  <= ST_IDLE;
          dly_q <= mem_rdata;
          if (at_end) begin
            ptr_q  <= '0;
            last_q <= last_lim;
          end else begin
            ptr_q <= ptr_q + PTR_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) seen_q <= rst_n;

  assign mem_rd    = (st_q == ST_RD);
  assign mem_wr    = (st_q == ST_WR);
  assign mem_col   = ptr_q[COL_W-1:0];
  assign mem_row   = ptr_q[PTR_W-1:COL_W];
  assign mem_wdata = smp_q;
  assign dly_out   = dly_q;

  p_rd_start_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (!mem_rd && !mem_wr && smp_stb) |=> mem_rd);

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    mem_rd |=> (mem_wr && $stable(mem_row) && $stable(mem_col)));

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    !(mem_rd && mem_wr));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    !mem_wr |=> $stable(dly_out));

  p_in_loop_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    ptr_q <= last_q);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (mem_wr && !at_end) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

  p_len_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    !$stable(last_q) |-> ($past(mem_wr) && ptr_q == '0));

  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    last_q <= LAST_CAP);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    mem_wr |=> !mem_rd);

endmodule

// File: tb/tb_delay_line_addr.sv
`timescale 1ns/1ps
module tb_delay_line_addr;
  localparam int SW = 8, CW = 3, RW = 2, MAXL = 27;
  localparam int PW = CW + RW, DEPTH = 1 << PW;

  logic clk = 0, rst_n = 0, smp_stb = 0;
  logic [SW-1:0] smp_in = '0, mem_wdata, mem_rdata, dly_out;
  logic [PW-1:0] loop_last = PW'(3);
  logic mem_rd, mem_wr;
  logic [RW-1:0] mem_row;
  logic [CW-1:0] mem_col;

  always #4 clk = ~clk;

  delay_line_addr #(.SMP_W(SW), .COL_W(CW), .ROW_W(RW), .MAX_LAST(MAXL)) dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .loop_last(loop_last), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dly_out(dly_out));

  logic [SW-1:0] ram [0:DEPTH-1];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
      mem_rdata <= '0;
    end else begin
      if (mem_rd) mem_rdata <= ram[{mem_row, mem_col}];
      if (mem_wr) ram[{mem_row, mem_col}] <= mem_wdata;
    end
  end

  int total = 0, bad = 0;
  bit done = 0;
  logic [SW-1:0] shadow [0:DEPTH-1];
  int mptr = 0, mlast = 0;
  bit pend = 0, capped = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int v);
    return (v > MAXL) ? MAXL : v;
  endfunction

  task automatic strobe(input logic [SW-1:0] d, input bit long);
    int ea = mptr;
    logic [SW-1:0] eq = shadow[mptr];
    logic [SW-1:0] hold;
    string areq = capped ? "R8" : (pend ? "R7" : "R6");
    @(negedge clk); smp_stb = 1; smp_in = d;
    @(negedge clk); if (!long) smp_stb = 0; smp_in = ~d;
    check("R2 rd", mem_rd, 1);
    check("R2 wr low", mem_wr, 0);
    check(areq, {mem_row, mem_col}, ea);
    check("R6 col field", mem_col, ea % (1 << CW));
    @(negedge clk); smp_stb = 0;
    check("R3 wr", mem_wr, 1);
    check(long ? "R9 no rd" : "R3 rd low", mem_rd, 0);
    check("R3 wdata", mem_wdata, d);
    check("R3 addr", {mem_row, mem_col}, ea);
    @(negedge clk);
    check("R5 delayed", dly_out, eq);
    check("R3 wr ends", mem_wr, 0);
    hold = dly_out;
    shadow[mptr] = d;
    if (mptr == mlast) begin
      mptr = 0; mlast = lim(loop_last); pend = 0;
    end else mptr++;
    @(negedge clk);
    check("R4 hold", dly_out, hold);
    check("R9 no extra rd", mem_rd, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (5) @(negedge clk);
    mlast = 3;
    check("R1 rd", mem_rd, 0);
    check("R1 wr", mem_wr, 0);
    check("R1 dout", dly_out, 0);
    check("R1 addr", {mem_row, mem_col}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 12; k++) strobe(SW'(k * 37 + 5), 0);
    strobe(8'h11, 0);
    loop_last = PW'(6); pend = 1;
    for (int k = 0; k < 20; k++) strobe(SW'(k * 13 + 90), 0);
    loop_last = PW'(31); pend = 1;
    for (int k = 0; k < 8; k++) strobe(SW'(k * 29 + 3), 0);
    capped = 1;
    for (int k = 0; k < 70; k++) strobe(SW'(k * 53 + 7), 0);
    capped = 0;
    loop_last = PW'(0); pend = 1;
    for (int k = 0; k < 36; k++) strobe(SW'(k * 71 + 1), k % 3 == 0);
    for (int k = 0; k < 6; k++) strobe(SW'(k * 19 + 200), 1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule